// File: doc/BRIEF.md
# Register Rename Unit with Commit-Time Release

This block renames architectural destination registers onto a single merged physical register file. A map table gives the physical register currently bound to each architectural register. A FIFO free list supplies fresh physical registers. When an instruction with a destination is renamed, the head of the free list becomes the new binding. The binding it displaces is handed back on `ren_old_phys`. That value travels with the instruction down the pipeline. When the instruction commits, the old binding is pushed onto the tail of the free list. A physical register is therefore reclaimed only after a younger writer of the same architectural register has retired. The block does not try to track the last reader of a register.

Each renamed branch takes a slot in a circular checkpoint queue. The slot holds the map table as seen by the instructions after the branch, together with the free-list read pointer. A misprediction names the slot of the branch that went wrong. The map table and the read pointer are reloaded from that slot, and every slot younger than it is dropped. Allocations made after the branch return to the free list in their original order. Branches release their slots in program order as they commit.

Each cycle the control resolves to one of three actions:
- `ACT_IDLE`: nothing changes except commit-side frees and releases.
- `ACT_RENAME`: a valid instruction is accepted.
- `ACT_RECOVER`: a misprediction is repaired.

The action is chosen afresh every cycle. `ACT_RECOVER` takes priority over `ACT_RENAME`, which takes priority over `ACT_IDLE`. Commit-side frees and slot releases happen in every action.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i reads as physical register i on both source lookup ports, and `ren_ready` is high for an instruction with a destination.
- R2: A rename with a destination returns the free-list head as `ren_new_phys` and the previous binding as `ren_old_phys`. Later lookups of that architectural register return the new binding. The first allocations after reset are 16, 17, 18, … in order.
- R3: A rename without a destination allocates nothing and leaves the map table unchanged.
- R4: A commit with a destination appends `cmt_old_phys` to the tail of the free list. It is handed out again only after every register ahead of it in the list.
- R5: A register freed by a commit cannot be allocated in the same cycle. With an empty free list, a same-cycle commit and destination rename leave `ren_ready` low, and the freed register is granted on the next cycle.
- R6: `ren_ready` is low for an instruction with a destination while the free list is empty.
- R7: A branch rename returns its checkpoint slot on `ren_ckpt_id`. Slots are granted in circular order 0, 1, 2, 3, 0, … The slot captures the map table including the branch's own destination, if any.
- R8: `ren_ready` is low for a branch while all 4 checkpoint slots are in use. A non-branch instruction is not blocked by a full checkpoint queue.
- R9: A recovery on slot k restores the map table saved in slot k. It also rolls the free list back, so the next allocation returns the first register allocated after that branch, in the original order.
- R10: A recovery on slot k keeps slot k and discards every younger slot, so the next branch receives slot k+1 (mod 4).
- R11: A commit with `cmt_branch` set releases the oldest checkpoint slot, making it available to a new branch.
- R12: `ren_ready` is low in any cycle where `fix_valid` is high, and no rename takes effect then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Instruction offered for rename |
| ren_has_dst | input | 1 | Instruction writes a destination register |
| ren_dst | input | 4 | Architectural destination |
| ren_branch | input | 1 | Instruction is a predicted branch and needs a checkpoint |
| ren_src_a | input | 4 | Architectural source A to look up |
| ren_src_b | input | 4 | Architectural source B to look up |
| ren_ready | output | 1 | Rename accepted this cycle when `ren_valid` is high |
| ren_new_phys | output | 6 | Physical register granted to the destination |
| ren_old_phys | output | 6 | Displaced binding of the destination |
| ren_ckpt_id | output | 2 | Checkpoint slot granted to a branch |
| ren_phys_a | output | 6 | Current binding of source A |
| ren_phys_b | output | 6 | Current binding of source B |
| cmt_valid | input | 1 | Oldest instruction commits |
| cmt_has_dst | input | 1 | Committing instruction had a destination |
| cmt_old_phys | input | 6 | Displaced binding carried by the committing instruction |
| cmt_branch | input | 1 | Committing instruction is a branch (releases oldest slot) |
| fix_valid | input | 1 | Misprediction repair request |
| fix_ckpt_id | input | 2 | Checkpoint slot of the mispredicted branch |

## Verification
The bench drains the free list completely and then lines up a commit and a destination rename in the same cycle. A design that forwarded the freed register would grant it one cycle early, and a design that lost the write would never grant it. It fills all four checkpoint slots, so an off-by-one full flag either overwrites a live snapshot or stalls a non-branch rename. It recovers to a middle slot and checks that the slot numbering resumes just after it and that the rolled-back registers come out in their original order. A long random phase mixes these cases, including wrap-around of both pointers. Any slip in pointer arithmetic then shows up as a wrong grant or a wrong source lookup against the behavioural model.

// File: rtl/rn_pkg.sv
package rn_pkg;
    // per-cycle action chosen by the rename control
    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,
        ACT_RENAME  = 2'd1,
        ACT_RECOVER = 2'd2
    } rn_act_e;
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
    parameter int NUM_ARCH = 16,
    parameter int NUM_PHYS = 48,
    parameter int PW       = 6,
    parameter int PTR_W    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic             free_en,
    input  logic [PW-1:0]    free_phys,
    input  logic             restore_en,
    input  logic [PTR_W-1:0] restore_rd,
    output logic [PW-1:0]    head_phys,
    output logic             empty,
    output logic [PTR_W-1:0] rd_ptr
);
    localparam int DEPTH = 1 << (PTR_W - 1);
    localparam int NFREE = NUM_PHYS - NUM_ARCH;

    logic [PW-1:0]    ring_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q, count;

    assign count     = wr_q - rd_q;
    assign empty     = (count == '0);
    assign head_phys = ring_q[rd_q[PTR_W-2:0]];
    assign rd_ptr    = rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                ring_q[i] <= (i < NFREE) ? PW'(NUM_ARCH + i) : '0;
            wr_q <= PTR_W'(NFREE);
            rd_q <= '0;
        end else begin
            if (free_en) begin
                ring_q[wr_q[PTR_W-2:0]] <= free_phys;
                wr_q <= wr_q + 1'b1;
            end
            if (restore_en)
                rd_q <= restore_rd;
            else if (alloc)
                rd_q <= rd_q + 1'b1;
        end
    end

    // R6: never hand out a register from an empty list (R5: frees this cycle do not count)
    p_alloc_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !empty);
    // R4: a free can only arrive while some register is outstanding
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        free_en |-> (count < PTR_W'(NFREE)));
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int NUM_ARCH = 16,
    parameter int PW       = 6,
    parameter int AW       = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_arch,
    input  logic [PW-1:0]                 wr_phys,
    input  logic                          restore_en,
    input  logic [NUM_ARCH-1:0][PW-1:0]   restore_map,
    output logic [NUM_ARCH-1:0][PW-1:0]   map_out
);
    logic [NUM_ARCH-1:0][PW-1:0] map_q;
    assign map_out = map_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ARCH; i++)
                map_q[i] <= PW'(i);
        end else if (restore_en) begin
            map_q <= restore_map;
        end else if (wr_en) begin
            map_q[wr_arch] <= wr_phys;
        end
    end

    // R2: a rename binding is visible on the next cycle
    p_rename_updates_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !restore_en) |=> map_out[$past(wr_arch)] == $past(wr_phys));
    // R12: a restore and a rename never collide
    p_restore_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        restore_en |-> !wr_en);
endmodule

// File: rtl/rn_ckpt_queue.sv
module rn_ckpt_queue #(
    parameter int NUM_CKPT = 4,   // power of two
    parameter int SNAP_W   = 103,
    parameter int IW       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [SNAP_W-1:0] push_data,
    input  logic              pop,
    input  logic              recover,
    input  logic [IW-1:0]     recover_id,
    output logic              full,
    output logic [IW-1:0]     tail_id,
    output logic [SNAP_W-1:0] snap_out
);
    localparam int CW = IW + 1;

    logic [SNAP_W-1:0] slot_q [NUM_CKPT];
    logic [IW-1:0]     head_q, tail_q, head_n, tail_n;
    logic [CW-1:0]     cnt_q, cnt_n;

    assign full     = (cnt_q == CW'(NUM_CKPT));
    assign tail_id  = tail_q;
    assign snap_out = slot_q[recover_id];

    always_comb begin
        head_n = head_q + IW'(pop);
        if (recover) begin
            tail_n = recover_id + 1'b1;
            cnt_n  = CW'(IW'(recover_id - head_n)) + 1'b1;
        end else begin
            tail_n = tail_q + IW'(push);
            cnt_n  = cnt_q + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            head_q <= head_n;
            tail_q <= tail_n;
            cnt_q  <= cnt_n;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !recover)
            slot_q[tail_q] <= push_data;
    end

    // R8: no snapshot is written over a live slot
    p_push_not_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R11: a release needs a live slot
    p_pop_live_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt_q != '0));
    // R10: after a recovery the next slot follows the recovered one
    p_recover_tail_r10: assert property (@(posedge clk) disable iff (!rst_n)
        recover |=> tail_q == IW'($past(recover_id) + 1'b1));
endmodule

// File: rtl/reg_rename.sv
module reg_rename #(
    parameter int NUM_ARCH = 16,
    parameter int NUM_PHYS = 48,
    parameter int NUM_CKPT = 4,
    localparam int AW      = $clog2(NUM_ARCH),
    localparam int PW      = $clog2(NUM_PHYS),
    localparam int IW      = $clog2(NUM_CKPT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren_valid,
    input  logic          ren_has_dst,
    input  logic [AW-1:0] ren_dst,
    input  logic          ren_branch,
    input  logic [AW-1:0] ren_src_a,
    input  logic [AW-1:0] ren_src_b,
    output logic          ren_ready,
    output logic [PW-1:0] ren_new_phys,
    output logic [PW-1:0] ren_old_phys,
    output logic [IW-1:0] ren_ckpt_id,
    output logic [PW-1:0] ren_phys_a,
    output logic [PW-1:0] ren_phys_b,
    input  logic          cmt_valid,
    input  logic          cmt_has_dst,
    input  logic [PW-1:0] cmt_old_phys,
    input  logic          cmt_branch,
    input  logic          fix_valid,
    input  logic [IW-1:0] fix_ckpt_id
);
    import rn_pkg::*;

    localparam int PTR_W  = PW + 1;
    localparam int MAP_W  = NUM_ARCH * PW;
    localparam int SNAP_W = MAP_W + PTR_W;

    logic [NUM_ARCH-1:0][PW-1:0] map_cur, map_next, map_saved;
    logic [PW-1:0]    fl_head;
    logic             fl_empty, cq_full;
    logic [PTR_W-1:0] fl_rd, rd_saved;
    logic [IW-1:0]    cq_tail;
    logic [SNAP_W-1:0] snap_push, snap_sel;
    rn_act_e          act;
    logic             do_alloc, do_push, do_restore;

    assign ren_ready = !fix_valid
                    && (!ren_has_dst || !fl_empty)
                    && (!ren_branch  || !cq_full);

    always_comb begin
        if (fix_valid)                   act = ACT_RECOVER;
        else if (ren_valid && ren_ready) act = ACT_RENAME;
        else                             act = ACT_IDLE;
    end

    always_comb begin
        do_alloc   = 1'b0;
        do_push    = 1'b0;
        do_restore = 1'b0;
        unique case (act)
            ACT_IDLE:    ;
            ACT_RENAME: begin
                do_alloc = ren_has_dst;
                do_push  = ren_branch;
            end
            ACT_RECOVER: do_restore = 1'b1;
            default:     ;
        endcase
    end

    // snapshot holds the view of instructions younger than the branch
    always_comb begin
        map_next = map_cur;
        if (ren_has_dst) map_next[ren_dst] = fl_head;
    end
    assign snap_push = {map_next, fl_rd + PTR_W'(do_alloc)};
    assign map_saved = snap_sel[SNAP_W-1:PTR_W];
    assign rd_saved  = snap_sel[PTR_W-1:0];

    assign ren_new_phys = fl_head;
    assign ren_old_phys = map_cur[ren_dst];
    assign ren_ckpt_id  = cq_tail;
    assign ren_phys_a   = map_cur[ren_src_a];
    assign ren_phys_b   = map_cur[ren_src_b];

    rn_map_table #(.NUM_ARCH(NUM_ARCH), .PW(PW), .AW(AW)) u_map (
        .clk(clk), .rst_n(rst_n),
        .wr_en(do_alloc), .wr_arch(ren_dst), .wr_phys(fl_head),
        .restore_en(do_restore), .restore_map(map_saved),
        .map_out(map_cur)
    );

    rn_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .PW(PW), .PTR_W(PTR_W)) u_free (
        .clk(clk), .rst_n(rst_n),
        .alloc(do_alloc),
        .free_en(cmt_valid && cmt_has_dst), .free_phys(cmt_old_phys),
        .restore_en(do_restore), .restore_rd(rd_saved),
        .head_phys(fl_head), .empty(fl_empty), .rd_ptr(fl_rd)
    );

    rn_ckpt_queue #(.NUM_CKPT(NUM_CKPT), .SNAP_W(SNAP_W), .IW(IW)) u_ckpt (
        .clk(clk), .rst_n(rst_n),
        .push(do_push), .push_data(snap_push),
        .pop(cmt_valid && cmt_branch),
        .recover(do_restore), .recover_id(fix_ckpt_id),
        .full(cq_full), .tail_id(cq_tail), .snap_out(snap_sel)
    );

    // R12: repair cycles accept no rename
    p_fix_blocks_rename_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fix_valid |-> !ren_ready);
    // R2: a destination never gets its own displaced register
    p_new_differs_old_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_ready && ren_has_dst) |-> (ren_new_phys != ren_old_phys));
    // R3: a rename without destination leaves the map unchanged
    p_nodst_keeps_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_ready && !ren_has_dst) |=> $stable(map_cur));
endmodule

// File: tb/reg_rename_test.sv
module reg_rename_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       ren_valid = 0, ren_has_dst = 0, ren_branch = 0;
    logic [3:0] ren_dst = 0, ren_src_a = 0, ren_src_b = 0;
    logic       ren_ready;
    logic [5:0] ren_new_phys, ren_old_phys, ren_phys_a, ren_phys_b;
    logic [1:0] ren_ckpt_id;
    logic       cmt_valid = 0, cmt_has_dst = 0, cmt_branch = 0;
    logic [5:0] cmt_old_phys = 0;
    logic       fix_valid = 0;
    logic [1:0] fix_ckpt_id = 0;

    reg_rename uut (.*);

    int checks = 0, fails = 0;
    bit done = 0;

    // behavioural model
    int mmap[16];
    int flq[$];
    int ahist[$];
    typedef struct { int m[16]; int acnt; int slot; } snap_t;
    snap_t sq[$];
    int nslot;
    typedef struct { bit dst; int oldp; bit br; int slot; } rob_t;
    rob_t rob[$];

    // last sampled outputs
    bit s_ready; int s_new, s_old, s_ckpt, s_pa;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(bit rv, bit hd, int dst, bit br, int sa, int sb, bit cv, bit fv, int fid);
        bit exp_ready, fire, cdst, cbr;
        int cold;
        rob_t e;
        @(negedge clk);
        cdst = 0; cbr = 0; cold = 0;
        if (cv && rob.size() > 0) begin
            cdst = rob[0].dst; cbr = rob[0].br; cold = rob[0].oldp;
        end else cv = 0;
        ren_valid = rv; ren_has_dst = hd; ren_dst = 4'(dst); ren_branch = br;
        ren_src_a = 4'(sa); ren_src_b = 4'(sb);
        cmt_valid = cv; cmt_has_dst = cdst; cmt_branch = cbr; cmt_old_phys = 6'(cold);
        fix_valid = fv; fix_ckpt_id = 2'(fid);
        #1;
        exp_ready = !fv && (!hd || flq.size() > 0) && (!br || sq.size() < 4);
        s_ready = ren_ready; s_new = ren_new_phys; s_old = ren_old_phys;
        s_ckpt = ren_ckpt_id; s_pa = ren_phys_a;
        chk(ren_ready == exp_ready, "R6/R8/R12 ready", ren_ready, exp_ready);
        chk(ren_phys_a == mmap[sa], "R1/R3/R9 src_a", ren_phys_a, mmap[sa]);
        chk(ren_phys_b == mmap[sb], "R1/R3/R9 src_b", ren_phys_b, mmap[sb]);
        fire = rv && exp_ready;
        if (fire && hd) begin
            chk(ren_new_phys == flq[0], "R2/R4/R9 new_phys", ren_new_phys, flq[0]);
            chk(ren_old_phys == mmap[dst], "R2 old_phys", ren_old_phys, mmap[dst]);
        end
        if (fire && br)
            chk(ren_ckpt_id == nslot, "R7/R10/R11 ckpt_id", ren_ckpt_id, nslot);
        @(posedge clk);
        // model update: commit first, then rename or recover
        if (cv) begin
            void'(rob.pop_front());
            if (cdst) flq.push_back(cold);
            if (cbr) void'(sq.pop_front());
        end
        if (fv) begin
            int k = -1;
            for (int i = 0; i < sq.size(); i++) if (sq[i].slot == fid) k = i;
            if (k >= 0) begin
                mmap = sq[k].m;
                while (ahist.size() > sq[k].acnt) flq.push_front(ahist.pop_back());
                while (sq.size() > k + 1) void'(sq.pop_back());
            end
            nslot = (fid + 1) % 4;
            begin
                int r = -1;
                for (int i = 0; i < rob.size(); i++) if (rob[i].br && rob[i].slot == fid) r = i;
                while (rob.size() > r + 1) void'(rob.pop_back());
            end
        end else if (fire) begin
            e.dst = hd; e.br = br; e.oldp = mmap[dst]; e.slot = nslot;
            if (hd) begin
                int p = flq.pop_front();
                ahist.push_back(p);
                mmap[dst] = p;
            end
            if (br) begin
                snap_t s;
                s.m = mmap; s.acnt = ahist.size(); s.slot = nslot;
                sq.push_back(s);
                nslot = (nslot + 1) % 4;
            end
            rob.push_back(e);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mmap[i] = i;
        for (int i = 16; i < 48; i++) flq.push_back(i);
        nslot = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset bindings
        for (int a = 0; a < 16; a++) begin
            cyc(0, 1, 0, 0, a, 15 - a, 0, 0, 0);
            chk(s_pa == a, "R1 reset map", s_pa, a);
        end
        chk(s_ready == 1, "R1 ready after reset", s_ready, 1);

        // R2: first allocation
        cyc(1, 1, 3, 0, 3, 3, 0, 0, 0);
        chk(s_new == 16 && s_old == 3, "R2 first grant", s_new, 16);
        // R3: no-destination rename leaves binding and free list alone
        cyc(1, 0, 3, 0, 3, 3, 0, 0, 0);
        chk(s_pa == 16, "R3 map kept", s_pa, 16);
        cyc(1, 1, 5, 0, 3, 5, 0, 0, 0);
        chk(s_new == 17, "R3 no allocation", s_new, 17);

        // exhaust the free list (R6)
        for (int i = 0; i < 30; i++) cyc(1, 1, i % 16, 0, i % 16, 0, 0, 0, 0);
        cyc(1, 1, 7, 0, 7, 0, 0, 0, 0);
        chk(s_ready == 0, "R6 empty stalls", s_ready, 0);

        // R5: same-cycle free is not forwarded; R4: granted next cycle
        cyc(1, 1, 7, 0, 7, 0, 1, 0, 0);
        chk(s_ready == 0, "R5 same-cycle stall", s_ready, 0);
        cyc(1, 1, 7, 0, 7, 0, 0, 0, 0);
        chk(s_ready == 1 && s_new == 3, "R4/R5 freed reg granted", s_new, 3);

        // drain
        while (rob.size() > 0) cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);

        // R7: four branches take slots 0..3
        for (int i = 0; i < 4; i++) begin
            cyc(1, 1, i + 1, 1, i + 1, 0, 0, 0, 0);
            chk(s_ready == 1 && s_ckpt == i, "R7 slot order", s_ckpt, i);
        end
        cyc(1, 1, 9, 1, 9, 0, 0, 0, 0);
        chk(s_ready == 0, "R8 full blocks branch", s_ready, 0);
        cyc(1, 1, 9, 0, 9, 1, 0, 0, 0);
        chk(s_ready == 1, "R8 non-branch passes", s_ready, 1);

        // R9/R10/R12: recover on slot 1
        cyc(1, 1, 4, 0, 2, 4, 0, 1, 1);
        chk(s_ready == 0, "R12 fix blocks rename", s_ready, 0);
        cyc(1, 1, 4, 1, 2, 3, 0, 0, 0);
        chk(s_ckpt == 2, "R10 slot after recovery", s_ckpt, 2);
        cyc(1, 0, 0, 1, 4, 9, 0, 0, 0);
        chk(s_ckpt == 3, "R10 next slot", s_ckpt, 3);
        // R11: committing oldest branch frees slot 0
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);
        cyc(1, 0, 0, 1, 1, 2, 0, 0, 0);
        chk(s_ready == 1 && s_ckpt == 0, "R11 slot released", s_ckpt, 0);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int brs[$];
            brs = {};
            for (int i = 0; i < rob.size(); i++) if (rob[i].br) brs.push_back(rob[i].slot);
            if (brs.size() > 0 && $urandom_range(15) == 0)
                cyc(0, 0, 0, 0, $urandom_range(15), $urandom_range(15), 0, 1,
                    brs[$urandom_range(brs.size() - 1)]);
            else
                cyc($urandom_range(3) != 0, $urandom_range(3) != 0, $urandom_range(15),
                    $urandom_range(4) == 0, $urandom_range(15), $urandom_range(15),
                    $urandom_range(1), 0, 0);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule